// File: doc/BRIEF.md
# Five-Source Interrupt Gathering Register

This block collects interrupt events from five sources into one 16-bit control register and drives a single combined interrupt line. The sources are a synchronous serial interface, an asynchronous serial interface, a tempo timer (timer 2), a sample-rate timer (timer 1) and an external line. Each source raises a one-cycle event pulse. The block holds that event in a per-source pending latch until software clears it.

Software sees one register address. The low byte holds a read/write enable bit for each source. The high byte, at the same relative bit positions, is written with ones to clear pending latches. When that byte is read, it shows the pending latches. Every write loads the enables and applies the clears together. Software that only wants to clear a latch must therefore write back the enables it wants to keep. The interrupt output is registered. It is high whenever any source is both pending and enabled. Choosing which source to service first, and producing a vector, is left to the consumer of the line.

Top module: `irq_collect`

## Requirements
- R1: While synchronous reset `rst` is high, and in the first cycle after it falls, every enable and every pending latch is 0: `rd_data` reads 0x0000 and `irq_out` is 0.
- R2: An event pulse on `evt_in[i]` sampled at a clock edge sets pending latch i at that edge, whatever its enable. Latch i reads back at bit 8+i of `rd_data`. The source index is 0 external, 1 timer 1 (sample), 2 timer 2 (tempo), 3 asynchronous serial, 4 synchronous serial.
- R3: A set pending latch stays set after its event input returns low, until a clear for that source is written.
- R4: A write (`wr_en` high at an edge) loads `wr_data[4:0]` into the enables for sources 0 to 4. The enables read back in `rd_data[4:0]` after that edge.
- R5: A write with `wr_data[8+i]` = 1 clears pending latch i. A 0 in that bit leaves the latch unchanged.
- R6: If an event for source i and a clear for source i occur at the same edge, latch i is set after that edge.
- R7: `irq_out` is a register output. After each edge it equals the OR over all sources of (pending AND enable), using the state that edge produced.
- R8: A write that carries clear bits also reloads the enables from the same write, in the same edge.
- R9: `wr_data` bits 15:13 and 7:5 have no effect. `rd_data` bits 15:13 and 7:5 always read 0.
- R10: Without a write, the enables keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data: enables in 4:0, write-one clears in 12:8 |
| rd_data | output | 16 | Read data: enables in 4:0, pending latches in 12:8 |
| evt_in | input | 5 | One-cycle event pulses, one per source |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
The hardest case to produce from the ports is an event pulse and a clear for the same source landing on the same edge. It only arises when the bench aligns the write strobe and the event input in one cycle. The bench does this on purpose: it drives both at the same falling edge, with the latch already set and also with it clear. In the same write it clears a different source, which shows that the clear logic still works for the other sources. Each source is also cycled alone through enable, event and clear, so that a wrong bit position in any lane shows up on `irq_out`.

// File: rtl/irq_collect_pkg.sv
package irq_collect_pkg;
  // Source indices; the bit position of each enable and clear follows this order.
  localparam int SRC_EXT  = 0;
  localparam int SRC_TMR1 = 1; // sample-rate timer
  localparam int SRC_TMR2 = 2; // tempo timer
  localparam int SRC_ASER = 3; // asynchronous serial interface
  localparam int SRC_SSER = 4; // synchronous serial interface

  localparam int DEF_NUM_SRC = 5;
  localparam int DEF_REG_W   = 16;
  localparam int DEF_CLR_LSB = 8;

  // Bits of the register that carry meaning for a given layout.
  function automatic logic [DEF_REG_W-1:0] used_mask(input int nsrc, input int clr_lsb);
    logic [DEF_REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < nsrc; k++) begin
      m[k]         = 1'b1;
      m[clr_lsb+k] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] en_wdata,
  output logic [NUM_SRC-1:0] ena,
  output logic [NUM_SRC-1:0] ena_nxt
);
  always_comb begin
    ena_nxt = wr_en ? en_wdata : ena;
  end

  always_ff @(posedge clk) begin
    if (rst) ena <= '0;
    else     ena <= ena_nxt;
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] pend_nxt
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    // An arriving event takes precedence over a clear in the same cycle.
    always_comb begin
      if (evt[i])      pend_nxt[i] = 1'b1;
      else if (clr[i]) pend_nxt[i] = 1'b0;
      else             pend_nxt[i] = pend[i];
    end

    always_ff @(posedge clk) begin
      if (rst) pend[i] <= 1'b0;
      else     pend[i] <= pend_nxt[i];
    end
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend_nxt,
  input  logic [NUM_SRC-1:0] ena_nxt,
  output logic               irq
);
  logic [NUM_SRC-1:0] live;

  always_comb begin
    live = pend_nxt & ena_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |live;
  end
endmodule

// File: rtl/irq_collect.sv
module irq_collect
  import irq_collect_pkg::*;
#(
  parameter int NUM_SRC = DEF_NUM_SRC,
  parameter int REG_W   = DEF_REG_W,
  parameter int CLR_LSB = DEF_CLR_LSB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic             irq_out
);
  localparam int CLR_MSB = CLR_LSB + NUM_SRC - 1;

  logic [NUM_SRC-1:0] ena, ena_nxt;
  logic [NUM_SRC-1:0] pend, pend_nxt;
  logic [NUM_SRC-1:0] clr_req;
  logic [REG_W-1:0]   used_bits;
  logic               unused_wr_bits;

  always_comb begin
    clr_req = wr_en ? wr_data[CLR_MSB:CLR_LSB] : '0;
  end

  irq_en_reg #(.NUM_SRC(NUM_SRC)) u_en (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .en_wdata (wr_data[NUM_SRC-1:0]),
    .ena      (ena),
    .ena_nxt  (ena_nxt)
  );

  irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_in),
    .clr      (clr_req),
    .pend     (pend),
    .pend_nxt (pend_nxt)
  );

  irq_out_stage #(.NUM_SRC(NUM_SRC)) u_out (
    .clk      (clk),
    .rst      (rst),
    .pend_nxt (pend_nxt),
    .ena_nxt  (ena_nxt),
    .irq      (irq_out)
  );

  // Read view built from flop outputs only; reserved bits tie to zero.
  for (genvar b = 0; b < REG_W; b++) begin : g_rd
    if (b < NUM_SRC) begin : g_en
      assign rd_data[b] = ena[b];
    end else if (b >= CLR_LSB && b <= CLR_MSB) begin : g_pd
      assign rd_data[b] = pend[b-CLR_LSB];
    end else begin : g_zero
      assign rd_data[b] = 1'b0;
    end
  end

  assign used_bits      = REG_W'(used_mask(NUM_SRC, CLR_LSB));
  assign unused_wr_bits = ^(wr_data & ~used_bits);
endmodule

// File: rtl/irq_collect_chk.sv
module irq_collect_chk #(
  parameter int NUM_SRC = 5,
  parameter int REG_W   = 16,
  parameter int CLR_LSB = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [REG_W-1:0]   wr_data,
  input logic [REG_W-1:0]   rd_data,
  input logic [NUM_SRC-1:0] evt_in,
  input logic               irq_out
);
  localparam int CLR_MSB = CLR_LSB + NUM_SRC - 1;

  // R1: reset leaves all state clear on the following cycle
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (rd_data == '0 && !irq_out));

  // R4 and R8: a write loads the enables
  p_en_load_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data[NUM_SRC-1:0] == $past(wr_data[NUM_SRC-1:0]));

  // R10: enables are held without a write
  p_en_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rd_data[NUM_SRC-1:0]));

  // R9: reserved read bits are zero
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_data[CLR_LSB-1:NUM_SRC] == '0) && (rd_data[REG_W-1:CLR_MSB+1] == '0));

  // R7: the interrupt line follows the pending and enable views
  p_irq_match_r7: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(rd_data[CLR_MSB:CLR_LSB] & rd_data[NUM_SRC-1:0]));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    // R2 and R6: an event always leaves the latch set
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
      evt_in[i] |=> rd_data[CLR_LSB+i]);

    // R3: a latch holds without a clear
    p_pend_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (rd_data[CLR_LSB+i] && !(wr_en && wr_data[CLR_LSB+i])) |=> rd_data[CLR_LSB+i]);

    // R5: a clear without an event empties the latch
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[CLR_LSB+i] && !evt_in[i]) |=> !rd_data[CLR_LSB+i]);

    // R2: a latch only rises from an event
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
      (!rd_data[CLR_LSB+i] && !evt_in[i]) |=> !rd_data[CLR_LSB+i]);
  end
endmodule

bind irq_collect irq_collect_chk #(
  .NUM_SRC(NUM_SRC), .REG_W(REG_W), .CLR_LSB(CLR_LSB)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .evt_in(evt_in), .irq_out(irq_out)
);

// File: tb/test_irq_collect.sv
`timescale 1ns/1ps
module test_irq_collect;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [4:0]  evt_in = '0;
  logic        irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  irq_collect i_irq_collect (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .evt_in(evt_in), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, the edge captures, the next negedge observes.
  task automatic step(input logic we, input logic [15:0] d, input logic [4:0] ev);
    wr_en = we; wr_data = d; evt_in = ev;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; evt_in = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1; idle(3);
    chk("R1 rd in reset", rd_data, 16'h0000);
    chk("R1 irq in reset", {15'b0, irq_out}, 16'h0000);
    rst = 1'b0; idle(1);
    chk("R1 rd after reset", rd_data, 16'h0000);
    chk("R1 irq after reset", {15'b0, irq_out}, 16'h0000);
  endtask

  task automatic t_enables();
    step(1'b1, 16'h00FF, 5'b0);
    chk("R4 enables load", rd_data, 16'h001F);
    chk("R9 bits 7:5 read zero", rd_data & 16'hE0E0, 16'h0000);
    step(1'b1, 16'hE00A, 5'b0);
    chk("R9 reserved write ignored", rd_data, 16'h000A);
    idle(4);
    chk("R10 enables held", rd_data, 16'h000A);
    step(1'b1, 16'h0000, 5'b0);
    chk("R4 enables cleared", rd_data, 16'h0000);
  endtask

  task automatic t_latch_and_clear();
    step(1'b0, 16'h0000, 5'b10101);
    chk("R2 events latch while disabled", rd_data, 16'h1500);
    chk("R7 no irq while disabled", {15'b0, irq_out}, 16'h0000);
    idle(3);
    chk("R3 latches held", rd_data, 16'h1500);
    step(1'b1, 16'h0004, 5'b0);
    chk("R7 irq on enable of pending", {15'b0, irq_out}, 16'h0001);
    step(1'b1, 16'h0404, 5'b0);
    chk("R5 clear source 2 only", rd_data, 16'h1104);
    chk("R7 irq drops after clear", {15'b0, irq_out}, 16'h0000);
    step(1'b1, 16'h1113, 5'b0);
    chk("R8 clear write reloads enables", rd_data, 16'h0013);
    chk("R7 irq low, nothing pending", {15'b0, irq_out}, 16'h0000);
    step(1'b1, 16'h0000, 5'b0);
  endtask

  task automatic t_set_wins();
    step(1'b0, 16'h0000, 5'b01010);
    chk("R2 sources 1 and 3 latch", rd_data, 16'h0A00);
    // same edge: clear 1 and 3, new event on 1
    step(1'b1, 16'h0A02, 5'b00010);
    chk("R6 event beats clear, other clear applies", rd_data, 16'h0202);
    chk("R7 irq with source 1", {15'b0, irq_out}, 16'h0001);
    // same edge on an empty latch
    step(1'b1, 16'h0202, 5'b0);
    chk("R5 clear source 1", rd_data, 16'h0002);
    step(1'b1, 16'h1002, 5'b10000);
    chk("R6 event beats clear on empty latch", rd_data, 16'h1002);
    chk("R7 disabled source gives no irq", {15'b0, irq_out}, 16'h0000);
    step(1'b1, 16'h1F00, 5'b0);
    chk("R5 clear all", rd_data, 16'h0000);
  endtask

  task automatic t_each_lane();
    for (int s = 0; s < 5; s++) begin
      logic [4:0] m;
      m = 5'(1 << s);
      step(1'b1, {11'b0, m}, 5'b0);
      chk("R7 no irq before event", {15'b0, irq_out}, 16'h0000);
      step(1'b0, 16'h0000, ~m);
      chk("R7 other lanes do not raise irq", {15'b0, irq_out}, 16'h0000);
      step(1'b0, 16'h0000, m);
      chk("R2 lane pend bit", rd_data, {3'b0, 5'h1F, 3'b0, m});
      chk("R7 lane irq", {15'b0, irq_out}, 16'h0001);
      step(1'b1, {3'b0, m, 3'b0, 5'b0}, 5'b0);
      chk("R5 lane clear", rd_data, {3'b0, ~m, 8'h00});
      step(1'b1, 16'h1F00, 5'b0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_enables();
    t_latch_and_clear();
    t_set_wins();
    t_each_lane();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule